// File: doc/BRIEF.md
# Four-Level Address Translation Walker

This block turns a 64-bit virtual address into a physical address by walking four levels of translation tables held in memory. A walk begins when `start` is pulsed while the block is idle. The block first confirms that the address is sign-extended from bit 47. It then reads one 64-bit table entry per level through a request/response memory port, starting from the table base given on `root_base`. The walk ends at a 4 KiB page after four reads, or at a 2 MiB page after three.

At every level the block checks the entry's present flag. It also folds the entry's writable, user-accessible and no-execute flags into a running permission set. When the walk finishes, it compares that set with the requested access type and privilege mode. It reports a physical address and the combined permissions, or a fault code together with the level at which the walk stopped. `done` pulses for one cycle when the result is ready. Only one walk runs at a time.

Top module: `xlat_walker`

## Requirements
- R1: If bits 63:47 of `vaddr` are not all equal when a walk is started, the block pulses `done` with `fault` = 1 (non-canonical) and `fault_level` = 0, and issues no memory read.
- R2: Level n (0 to 3) uses virtual-address bits [47-9n : 39-9n] as its index, and its read address is the table base plus index times 8. Level 0 takes its base from `root_base`. Each later level takes its base from entry bits 51:12 of the level above, with 12 zero bits appended.
- R3: An entry with bit 0 (present) clear ends the walk at once, with `fault` = 2 (not-present), `fault_level` equal to that entry's level, and no further read.
- R4: A present entry at level 2 with bit 7 set is a 2 MiB leaf. The walk ends after three reads, `paddr` = {entry[51:21], vaddr[20:0]} and `fault_level` = 2.
- R5: A present entry at level 3 is a 4 KiB leaf. The walk ends after four reads, `paddr` = {entry[51:12], vaddr[11:0]} and `fault_level` = 3. `perm_w` is the AND of bit 1 over the visited entries, `perm_u` is the AND of bit 2, and `perm_x` is set only when no visited entry has bit 63 set.
- R6: `acc_type` is encoded 0 = read, 1 = write, 2 = execute. A write needs `perm_w`, `user_mode` = 1 needs `perm_u`, and an execute needs `perm_x`. A violation gives `fault` = 3 (protection) at the leaf level. On any fault, `paddr`, `perm_w`, `perm_u` and `perm_x` read 0, and `fault` = 0 means success.
- R7: `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready` is seen. At most one read is outstanding, and the next request follows only after `mem_rsp_valid`.
- R8: A `start` while idle is accepted. `busy` is high from the following cycle until the result. `done` is a one-cycle pulse during which `busy` is low. A `start` while busy is ignored.
- R9: Synchronous active-high `rst` returns the block to idle, aborting any walk. `busy`, `done` and `mem_req_valid` go low, and `fault` and `paddr` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (taken only while idle) |
| vaddr | input | 64 | Virtual address to translate |
| acc_type | input | 2 | 0 read, 1 write, 2 execute |
| user_mode | input | 1 | 1 = user privilege, 0 = supervisor |
| root_base | input | 52 | Physical base of the level-0 table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 52 | Physical address of the entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Entry contents |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result pulse |
| fault | output | 2 | 0 none, 1 non-canonical, 2 not-present, 3 protection |
| fault_level | output | 2 | Level at which the walk stopped |
| paddr | output | 52 | Translated physical address |
| perm_w | output | 1 | Combined writable permission |
| perm_u | output | 1 | Combined user permission |
| perm_x | output | 1 | Combined execute permission |

## Verification
The assertions assume that memory raises `mem_rsp_valid` only for a request it has accepted, and only once per request. They also assume `root_base` and the table bases are 4 KiB aligned and that `start` is not driven during reset. The bench's memory model answers exactly one cycle after each accepted request and stores every table at a 4 KiB boundary. It holds `mem_req_ready` low only in a dedicated stall test and releases reset before the first `start`. Entries missing from the model read as zero, so they model not-present entries.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    FLT_NONE     = 2'd0,
    FLT_NONCANON = 2'd1,
    FLT_NOTPRES  = 2'd2,
    FLT_PROT     = 2'd3
  } flt_e;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  localparam int BIT_PRES  = 0;
  localparam int BIT_RW    = 1;
  localparam int BIT_USER  = 2;
  localparam int BIT_LARGE = 7;
  localparam int BIT_NOX   = 63;

  // every bit from vaw-1 upward must match bit vaw-1
  function automatic logic is_canon(input logic [63:0] va, input int unsigned vaw);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < 64; i++)
      if (i >= int'(vaw) && va[i] != va[vaw-1]) ok = 1'b0;
    return ok;
  endfunction
endpackage

// File: rtl/xlat_va_split.sv
module xlat_va_split #(
  parameter int VA_W   = 48,
  parameter int IDX_W  = 9,
  parameter int LEVELS = 4,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic [VA_W-1:0]  va,
  input  logic [LVL_W-1:0] lvl,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] idx_arr [LEVELS];

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    assign idx_arr[l] = va[VA_W-1-l*IDX_W -: IDX_W];
  end

  assign idx = idx_arr[lvl];
endmodule

// File: rtl/xlat_perm_acc.sv
module xlat_perm_acc (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic upd,
  input  logic ent_rw,
  input  logic ent_user,
  input  logic ent_nox,
  output logic w_now,
  output logic u_now,
  output logic x_now
);
  logic w_q, u_q, x_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      w_q <= 1'b1;
      u_q <= 1'b1;
      x_q <= 1'b1;
    end else if (upd) begin
      w_q <= w_q & ent_rw;
      u_q <= u_q & ent_user;
      x_q <= x_q & ~ent_nox;
    end
  end

  // permissions including the entry currently on the response bus
  assign w_now = w_q & ent_rw;
  assign u_now = u_q & ent_user;
  assign x_now = x_q & ~ent_nox;
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int VA_W   = 48,
  parameter int PA_W   = 52,
  parameter int ENT_W  = 64,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int LEVELS = 4,
  localparam int LVL_W  = $clog2(LEVELS),
  localparam int LG_LVL = LEVELS - 2,
  localparam int LG_OFF = OFF_W + IDX_W,
  localparam int ESZ_SH = $clog2(ENT_W / 8)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [63:0]      vaddr,
  input  logic [1:0]       acc_type,
  input  logic             user_mode,
  input  logic [PA_W-1:0]  root_base,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [ENT_W-1:0] mem_rsp_data,
  output logic             busy,
  output logic             done,
  output logic [1:0]       fault,
  output logic [LVL_W-1:0] fault_level,
  output logic [PA_W-1:0]  paddr,
  output logic             perm_w,
  output logic             perm_u,
  output logic             perm_x
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_e;

  st_e              st;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       acc_q;
  logic             usr_q;
  logic [PA_W-1:0]  base_q;
  logic [LVL_W-1:0] lvl_q;
  logic             busy_q, done_q;
  logic [1:0]       flt_q;
  logic [LVL_W-1:0] flvl_q;
  logic [PA_W-1:0]  pa_q;
  logic             pw_q, pu_q, px_q;

  logic [IDX_W-1:0] idx;
  logic             w_now, u_now, x_now;
  logic             ent_p, is_leaf, is_large, viol;
  logic             accept, unused_bits;

  xlat_va_split #(.VA_W(VA_W), .IDX_W(IDX_W), .LEVELS(LEVELS)) u_split (
    .va(va_q), .lvl(lvl_q), .idx(idx)
  );

  assign ent_p    = mem_rsp_data[BIT_PRES];
  assign is_large = (lvl_q == LVL_W'(LG_LVL)) && mem_rsp_data[BIT_LARGE];
  assign is_leaf  = (lvl_q == LVL_W'(LEVELS-1)) || is_large;
  assign viol     = (acc_q == ACC_WRITE && !w_now) ||
                    (usr_q && !u_now) ||
                    (acc_q == ACC_EXEC && !x_now);
  assign accept   = (st == S_IDLE) && start;

  xlat_perm_acc u_perm (
    .clk(clk), .rst(rst),
    .clear(accept),
    .upd(st == S_WAIT && mem_rsp_valid && ent_p && !is_leaf),
    .ent_rw(mem_rsp_data[BIT_RW]),
    .ent_user(mem_rsp_data[BIT_USER]),
    .ent_nox(mem_rsp_data[BIT_NOX]),
    .w_now(w_now), .u_now(u_now), .x_now(x_now)
  );

  assign unused_bits = ^{mem_rsp_data[ENT_W-2:PA_W], mem_rsp_data[OFF_W-1:BIT_LARGE+1],
                         mem_rsp_data[BIT_LARGE-1:BIT_USER+1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      va_q   <= '0;
      acc_q  <= ACC_READ;
      usr_q  <= 1'b0;
      base_q <= '0;
      lvl_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      flt_q  <= FLT_NONE;
      flvl_q <= '0;
      pa_q   <= '0;
      pw_q   <= 1'b0;
      pu_q   <= 1'b0;
      px_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          va_q  <= vaddr[VA_W-1:0];
          acc_q <= acc_type;
          usr_q <= user_mode;
          if (!is_canon(vaddr, VA_W)) begin
            done_q <= 1'b1;
            flt_q  <= FLT_NONCANON;
            flvl_q <= '0;
            pa_q   <= '0;
            pw_q   <= 1'b0;
            pu_q   <= 1'b0;
            px_q   <= 1'b0;
          end else begin
            busy_q <= 1'b1;
            base_q <= root_base;
            lvl_q  <= '0;
            st     <= S_REQ;
          end
        end
        S_REQ: if (mem_req_ready) st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (!ent_p || is_leaf) begin
            st     <= S_IDLE;
            busy_q <= 1'b0;
            done_q <= 1'b1;
            flvl_q <= lvl_q;
            if (!ent_p || viol) begin
              flt_q <= !ent_p ? FLT_NOTPRES : FLT_PROT;
              pa_q  <= '0;
              pw_q  <= 1'b0;
              pu_q  <= 1'b0;
              px_q  <= 1'b0;
            end else begin
              flt_q <= FLT_NONE;
              pa_q  <= is_large ? {mem_rsp_data[PA_W-1:LG_OFF], va_q[LG_OFF-1:0]}
                                : {mem_rsp_data[PA_W-1:OFF_W], va_q[OFF_W-1:0]};
              pw_q  <= w_now;
              pu_q  <= u_now;
              px_q  <= x_now;
            end
          end else begin
            base_q <= {mem_rsp_data[PA_W-1:OFF_W], {OFF_W{1'b0}}};
            lvl_q  <= lvl_q + 1'b1;
            st     <= S_REQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (st == S_REQ);
  assign mem_req_addr  = base_q + (PA_W'(idx) << ESZ_SH);
  assign busy          = busy_q;
  assign done          = done_q;
  assign fault         = flt_q;
  assign fault_level   = flvl_q;
  assign paddr         = pa_q;
  assign perm_w        = pw_q;
  assign perm_u        = pu_q;
  assign perm_x        = px_q;
endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk #(
  parameter int PA_W  = 52,
  parameter int LVL_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic             busy,
  input logic             done,
  input logic [1:0]       fault,
  input logic [LVL_W-1:0] fault_level,
  input logic [PA_W-1:0]  paddr,
  input logic             perm_w,
  input logic             perm_u,
  input logic             perm_x
);
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R7
  req_in_walk_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> busy);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R1
  noncanon_level_chk: assert property (@(posedge clk) disable iff (rst)
    done && fault == 2'd1 |-> fault_level == '0);

  // R6
  fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
    done && fault != 2'd0 |-> paddr == '0 && !perm_w && !perm_u && !perm_x);
endmodule

bind xlat_walker xlat_walker_chk #(.PA_W(PA_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .busy(busy), .done(done),
  .fault(fault), .fault_level(fault_level), .paddr(paddr),
  .perm_w(perm_w), .perm_u(perm_u), .perm_x(perm_x)
);

// File: tb/xlat_walker_tb.sv
module xlat_walker_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [63:0] vaddr = '0;
  logic [1:0]  acc_type = '0;
  logic        user_mode = 1'b0;
  logic [51:0] root_base = 52'h1000;
  logic        mem_req_valid, mem_req_ready;
  logic [51:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        busy, done, perm_w, perm_u, perm_x;
  logic [1:0]  fault, fault_level;
  logic [51:0] paddr;

  logic        rdy_en = 1'b1;
  int          reads = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  logic [63:0] mem [logic [51:0]];

  always #4 clk = ~clk;  // 125 MHz

  assign mem_req_ready = rdy_en;

  xlat_walker u_dut (
    .clk(clk), .rst(rst), .start(start), .vaddr(vaddr), .acc_type(acc_type),
    .user_mode(user_mode), .root_base(root_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .busy(busy), .done(done), .fault(fault),
    .fault_level(fault_level), .paddr(paddr),
    .perm_w(perm_w), .perm_u(perm_u), .perm_x(perm_x)
  );

  // memory model: one-cycle read latency, absent entries read as zero
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'h0;
      reads         <= reads + 1;
    end
  end

  typedef struct packed {
    logic [63:0] va;
    logic [1:0]  acc;
    logic        usr;
    logic [1:0]  flt;
    logic [1:0]  lvl;
    logic [51:0] pa;
    logic        w, u, x;
    logic [2:0]  nrd;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    // R5 4 KiB leaf, user read / write / execute
    '{64'h0000_0080_8060_4567, 2'd0, 1'b1, 2'd0, 2'd3, 52'h000_0ABC_D567, 1'b1, 1'b1, 1'b1, 3'd4},
    '{64'h0000_0080_8060_4567, 2'd1, 1'b1, 2'd0, 2'd3, 52'h000_0ABC_D567, 1'b1, 1'b1, 1'b1, 3'd4},
    '{64'h0000_0080_8060_4567, 2'd2, 1'b1, 2'd0, 2'd3, 52'h000_0ABC_D567, 1'b1, 1'b1, 1'b1, 3'd4},
    // R4 2 MiB leaf
    '{64'h0000_0080_80A1_2345, 2'd0, 1'b1, 2'd0, 2'd2, 52'h000_4001_2345, 1'b1, 1'b1, 1'b1, 3'd3},
    '{64'h0000_0080_80A1_2345, 2'd1, 1'b0, 2'd0, 2'd2, 52'h000_4001_2345, 1'b1, 1'b1, 1'b1, 3'd3},
    // R6 read-only leaf: read ok, write faults
    '{64'h0000_0080_8060_6010, 2'd0, 1'b1, 2'd0, 2'd3, 52'h000_0000_5010, 1'b0, 1'b1, 1'b1, 3'd4},
    '{64'h0000_0080_8060_6010, 2'd1, 1'b1, 2'd3, 2'd3, 52'h0,             1'b0, 1'b0, 1'b0, 3'd4},
    // R6 supervisor-only middle level
    '{64'h0000_0081_C000_00AB, 2'd0, 1'b0, 2'd0, 2'd3, 52'h000_0000_80AB, 1'b1, 1'b0, 1'b1, 3'd4},
    '{64'h0000_0081_C000_00AB, 2'd0, 1'b1, 2'd3, 2'd3, 52'h0,             1'b0, 1'b0, 1'b0, 3'd4},
    // R6 no-execute leaf
    '{64'h0000_0080_8060_8020, 2'd0, 1'b0, 2'd0, 2'd3, 52'h000_0000_9020, 1'b1, 1'b1, 1'b0, 3'd4},
    '{64'h0000_0080_8060_8020, 2'd2, 1'b0, 2'd3, 2'd3, 52'h0,             1'b0, 1'b0, 1'b0, 3'd4},
    // R3 not-present at levels 0, 1 (upper half), 2, 3
    '{64'h0000_0000_0000_1000, 2'd0, 1'b0, 2'd2, 2'd0, 52'h0,             1'b0, 1'b0, 1'b0, 3'd1},
    '{64'hFFFF_8000_0000_0000, 2'd0, 1'b0, 2'd2, 2'd1, 52'h0,             1'b0, 1'b0, 1'b0, 3'd2},
    '{64'h0000_0080_8120_0000, 2'd0, 1'b0, 2'd2, 2'd2, 52'h0,             1'b0, 1'b0, 1'b0, 3'd3},
    '{64'h0000_0080_8060_A000, 2'd0, 1'b0, 2'd2, 2'd3, 52'h0,             1'b0, 1'b0, 1'b0, 3'd4},
    // R1 non-canonical
    '{64'h0001_0000_0000_0000, 2'd0, 1'b0, 2'd1, 2'd0, 52'h0,             1'b0, 1'b0, 1'b0, 3'd0}
  };

  task automatic check(input string req, input logic ok, input string msg);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s", req, msg);
    end
  endtask

  task automatic walk(input vec_t v, input string req);
    int r0, n;
    @(negedge clk);
    r0 = reads;
    vaddr = v.va; acc_type = v.acc; user_mode = v.usr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    check(req, done && fault == v.flt && fault_level == v.lvl && paddr == v.pa &&
          perm_w == v.w && perm_u == v.u && perm_x == v.x && (reads - r0) == int'(v.nrd),
          $sformatf("va=%h act flt=%0d lvl=%0d pa=%h wux=%b%b%b rd=%0d done=%b exp flt=%0d lvl=%0d pa=%h wux=%b%b%b rd=%0d",
                    v.va, fault, fault_level, paddr, perm_w, perm_u, perm_x, reads - r0, done,
                    v.flt, v.lvl, v.pa, v.w, v.u, v.x, v.nrd));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    mem[52'h1008] = 64'h2007;               // L0[1] -> 0x2000
    mem[52'h1800] = 64'h2007;               // L0[256] -> 0x2000
    mem[52'h2010] = 64'h3007;               // L1[2] -> 0x3000
    mem[52'h2038] = 64'h6003;               // L1[7] supervisor only
    mem[52'h3018] = 64'h4007;               // L2[3] -> 0x4000
    mem[52'h3028] = 64'h4000_0087;          // L2[5] 2 MiB page
    mem[52'h4020] = 64'h0ABC_D007;          // L3[4]
    mem[52'h4030] = 64'h5005;               // L3[6] read-only
    mem[52'h4040] = 64'h8000_0000_0000_9007; // L3[8] no-execute
    mem[52'h6000] = 64'h7007;
    mem[52'h7000] = 64'h8007;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9", !busy && !done && !mem_req_valid && fault == 2'd0 && paddr == '0,
          $sformatf("act busy=%b done=%b req=%b flt=%0d pa=%h exp 0 0 0 0 0",
                    busy, done, mem_req_valid, fault, paddr));

    for (int i = 0; i < NV; i++) walk(VECS[i], "R2/R3/R4/R5/R6/R1");

    // R7 stall: request held with the level-0 address; R8 start while busy ignored
    @(negedge clk);
    rdy_en = 1'b0;
    vaddr = VECS[0].va; acc_type = 2'd0; user_mode = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8", busy, $sformatf("busy after start act=%b exp=1", busy));
    repeat (4) @(negedge clk);
    check("R7", mem_req_valid && mem_req_addr == 52'h1008,
          $sformatf("stalled req act v=%b a=%h exp v=1 a=1008", mem_req_valid, mem_req_addr));
    vaddr = 64'h0001_0000_0000_0000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8", !done && busy, $sformatf("start while busy act done=%b busy=%b exp 0 1", done, busy));
    rdy_en = 1'b1;
    for (int n = 0; n < 50 && !done; n++) @(negedge clk);
    check("R8", done && !busy && fault == 2'd0 && paddr == 52'h0ABC_D567,
          $sformatf("after stall act done=%b busy=%b flt=%0d pa=%h exp 1 0 0 abcd567",
                    done, busy, fault, paddr));
    @(negedge clk);
    check("R8", !done, $sformatf("done pulse width act=%b exp=0", done));

    // R9 reset mid-walk
    vaddr = VECS[0].va; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9", !busy && !done && !mem_req_valid && paddr == '0,
          $sformatf("mid-walk reset act busy=%b done=%b req=%b pa=%h exp 0 0 0 0",
                    busy, done, mem_req_valid, paddr));
    repeat (3) @(negedge clk);
    check("R9", !busy && !done, $sformatf("idle after reset act busy=%b done=%b exp 0 0", busy, done));

    // R1 negative upper-half non-canonical
    walk('{64'hFFFF_0000_0000_0000, 2'd0, 1'b0, 2'd1, 2'd0, 52'h0, 1'b0, 1'b0, 1'b0, 3'd0}, "R1");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule